// File: doc/BRIEF.md
# Banked Data Memory with Access-Bank Addressing

This block is the 4 KB byte-wide data space of a small 8-bit processor core. Each access carries an 8-bit file address from the instruction and a one-bit bank flag. When the flag is set, a 4-bit page register picks one of sixteen 256-byte pages and the physical address is that page number placed above the file address. When the flag is clear, the page register plays no part. A fixed window is used instead: the low part of the file address range lands at the bottom of page 0, and the rest lands in the special-function area at the top of page 15.

The block keeps general-purpose RAM in internal storage for physical addresses 0x000 to 0xF3F. It sends special-function-register traffic (0xF5A to 0xFFF) to an external register port, and it refuses the unimplemented gap at 0xF40 to 0xF59. The page register is loaded through its own write enable. Every read returns its data one cycle after the request, together with a valid flag.

Top module: `banked_dmem`

## Requirements
- R1: The page register resets to 0. When `bsr_we` is high, it loads the low 4 bits of `bsr_wdata` at the clock edge, and the value shows on `bsr_q` from the next cycle.
- R2: With `bank_sel` = 1, the physical address is {`bsr_q`, `faddr`}. The same file address in different pages reaches different RAM bytes.
- R3: With `bank_sel` = 0 and `faddr` below 0x60, the access goes to RAM at physical 0x000 + `faddr` whatever the page register holds. No register-port strobe is raised.
- R4: With `bank_sel` = 0 and `faddr` at 0x60 or above, the access goes to the register port at physical address 0xF00 + `faddr` whatever the page register holds.
- R5: A RAM read returns the stored byte on `rdata`, with `rvalid` high, in the cycle after `rd_en` was sampled. A RAM write takes effect at the clock edge.
- R6: For a register-port access, `sfr_we` or `sfr_re` is high in the same cycle, with `sfr_addr` set to the physical address and `sfr_wdata` set to `wdata`. The byte on `sfr_rdata` during a read is returned on `rdata` with `rvalid` one cycle later. RAM is not written.
- R7: Physical 0xF5A to 0xF5F can be reached only with `bank_sel` = 1 and the page register at 15. There they go to the register port. In the access window, file addresses 0x5A to 0x5F are RAM.
- R8: An access to physical 0xF40 to 0xF59 raises no port strobe and changes no storage. A read there returns 0x00 with `rvalid`. `err` is high for exactly the cycle after each such access.
- R9: Reset does not clear the RAM contents.
- R10: `rvalid` is low in any cycle that does not follow a read. `err` is low in any cycle that does not follow an access to the gap. Both are low out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bsr_we | input | 1 | Load enable of the page register |
| bsr_wdata | input | 8 | Value for the page register (low 4 bits kept) |
| bsr_q | output | 4 | Current page register |
| bank_sel | input | 1 | 1: use page register, 0: fixed access window |
| faddr | input | 8 | File address from the instruction |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after the request |
| rvalid | output | 1 | `rdata` holds the result of the previous cycle's read |
| err | output | 1 | One-cycle pulse after an access to the unimplemented gap |
| sfr_addr | output | 12 | Register-port physical address |
| sfr_wdata | output | 8 | Register-port write data |
| sfr_we | output | 1 | Register-port write strobe |
| sfr_re | output | 1 | Register-port read strobe |
| sfr_rdata | input | 8 | Register-port read data, combinational |

## Verification
The assertions check these rules on every cycle:
- how the page register loads;
- the address the register port sees in both addressing modes;
- that the access window never strobes the port for low file addresses;
- the error pulse that follows a gap access;
- the one-cycle relation between read requests, `rvalid` and returned port data.

Only the bench scenarios can show that bytes actually land at the right RAM location. They write through one mode or page and read back through another. They also show that a register-port or gap write leaves RAM alone, and that stored bytes survive a reset.

// File: rtl/banked_dmem.sv
module banked_dmem #(
  parameter int FILE_W    = 8,
  parameter int BANK_W    = 4,
  parameter int DATA_W    = 8,
  parameter int ACC_SPLIT = 'h60,
  parameter int HOLE_LO   = 'hF40,
  parameter int SFR_LO    = 'hF5A
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bsr_we,
  input  logic [DATA_W-1:0]          bsr_wdata,
  output logic [BANK_W-1:0]          bsr_q,
  input  logic                       bank_sel,
  input  logic [FILE_W-1:0]          faddr,
  input  logic                       rd_en,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rvalid,
  output logic                       err,
  output logic [FILE_W+BANK_W-1:0]   sfr_addr,
  output logic [DATA_W-1:0]          sfr_wdata,
  output logic                       sfr_we,
  output logic                       sfr_re,
  input  logic [DATA_W-1:0]          sfr_rdata
);
  localparam int PHYS_W = FILE_W + BANK_W;
  localparam int RAM_DEPTH = HOLE_LO;
  localparam logic [FILE_W-1:0] SPLIT_A = FILE_W'(ACC_SPLIT);
  localparam logic [PHYS_W-1:0] HOLE_A = PHYS_W'(HOLE_LO);
  localparam logic [PHYS_W-1:0] SFR_A = PHYS_W'(SFR_LO);

  logic [BANK_W-1:0] bsr;
  logic [PHYS_W-1:0] phys;
  logic              in_ram, in_sfr, in_hole, any_acc;
  logic [DATA_W-1:0] mem [RAM_DEPTH];
  logic [DATA_W-1:0] ram_q, sfr_q;
  logic              sel_ram, sel_sfr;

  assign phys = bank_sel        ? {bsr, faddr} :
                (faddr < SPLIT_A) ? {{BANK_W{1'b0}}, faddr} :
                                    {{BANK_W{1'b1}}, faddr};

  assign in_ram  = phys < HOLE_A;
  assign in_sfr  = phys >= SFR_A;
  assign in_hole = !in_ram && !in_sfr;
  assign any_acc = rd_en || wr_en;

  assign sfr_addr  = phys;
  assign sfr_wdata = wdata;
  assign sfr_we    = wr_en && in_sfr;
  assign sfr_re    = rd_en && in_sfr;
  assign bsr_q     = bsr;

  always_ff @(posedge clk) begin
    if (wr_en && in_ram) mem[phys] <= wdata;
    if (rd_en && in_ram) ram_q <= mem[phys];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsr     <= '0;
      rvalid  <= 1'b0;
      err     <= 1'b0;
      sel_ram <= 1'b0;
      sel_sfr <= 1'b0;
      sfr_q   <= '0;
    end else begin
      if (bsr_we) bsr <= bsr_wdata[BANK_W-1:0];
      rvalid <= rd_en;
      err    <= any_acc && in_hole;
      if (rd_en) begin
        sel_ram <= in_ram;
        sel_sfr <= in_sfr;
        sfr_q   <= sfr_rdata;
      end
    end
  end

  assign rdata = sel_ram ? ram_q : sel_sfr ? sfr_q : '0;
endmodule

// File: rtl/banked_dmem_chk.sv
module banked_dmem_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bsr_we,
  input logic [7:0]  bsr_wdata,
  input logic [3:0]  bsr_q,
  input logic        bank_sel,
  input logic [7:0]  faddr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  rdata,
  input logic        rvalid,
  input logic        err,
  input logic [11:0] sfr_addr,
  input logic        sfr_we,
  input logic        sfr_re,
  input logic [7:0]  sfr_rdata
);
  logic gap_hit;
  assign gap_hit = (rd_en || wr_en) && bank_sel && bsr_q == 4'hF &&
                   faddr >= 8'h40 && faddr <= 8'h59;

  AST_BSR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_we |=> bsr_q == $past(bsr_wdata[3:0])); // R1
  AST_BANKED_PORT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel && (sfr_we || sfr_re) |-> sfr_addr == {bsr_q, faddr}); // R2
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid); // R5
  AST_WINDOW_LOW_NO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_sel && faddr < 8'h60 |-> !sfr_we && !sfr_re); // R3
  AST_WINDOW_HIGH_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_sel && faddr >= 8'h60 && wr_en |-> sfr_we && sfr_addr == {4'hF, faddr}); // R4
  AST_PORT_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_re |=> rvalid && rdata == $past(sfr_rdata)); // R6
  AST_EXPLICIT_SFR_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && bank_sel && bsr_q == 4'hF && faddr >= 8'h5A |-> sfr_re); // R7
  AST_GAP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    gap_hit |-> !sfr_we && !sfr_re); // R8
  AST_GAP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    gap_hit |=> err); // R8
  AST_NO_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid); // R10
  AST_NO_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |=> !err); // R10
endmodule

bind banked_dmem banked_dmem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bsr_we(bsr_we), .bsr_wdata(bsr_wdata),
  .bsr_q(bsr_q), .bank_sel(bank_sel), .faddr(faddr), .rd_en(rd_en),
  .wr_en(wr_en), .rdata(rdata), .rvalid(rvalid), .err(err),
  .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_re(sfr_re),
  .sfr_rdata(sfr_rdata)
);

// File: tb/tb_banked_dmem.sv
`timescale 1ns/1ps
module tb_banked_dmem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bsr_we = 1'b0;
  logic [7:0]  bsr_wdata = '0;
  logic [3:0]  bsr_q;
  logic        bank_sel = 1'b0;
  logic [7:0]  faddr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid, err;
  logic [11:0] sfr_addr;
  logic [7:0]  sfr_wdata;
  logic        sfr_we, sfr_re;
  logic [7:0]  sfr_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sfr_rdata = sfr_addr[7:0] ^ 8'hC3;

  banked_dmem dut (
    .clk(clk), .rst_n(rst_n), .bsr_we(bsr_we), .bsr_wdata(bsr_wdata),
    .bsr_q(bsr_q), .bank_sel(bank_sel), .faddr(faddr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .err(err), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_re(sfr_re), .sfr_rdata(sfr_rdata)
  );

  // {is_read, bank_sel, page, faddr, data}
  localparam logic [21:0] VEC [14] = '{
    {1'b0, 1'b1, 4'd3,  8'h10, 8'hA5},
    {1'b0, 1'b1, 4'd0,  8'h10, 8'h3C},
    {1'b1, 1'b1, 4'd3,  8'h10, 8'hA5},
    {1'b1, 1'b0, 4'd7,  8'h10, 8'h3C},
    {1'b0, 1'b0, 4'd9,  8'h5F, 8'h77},
    {1'b1, 1'b1, 4'd0,  8'h5F, 8'h77},
    {1'b0, 1'b1, 4'd14, 8'hFF, 8'h11},
    {1'b1, 1'b1, 4'd14, 8'hFF, 8'h11},
    {1'b0, 1'b1, 4'd15, 8'h3F, 8'h99},
    {1'b1, 1'b1, 4'd15, 8'h3F, 8'h99},
    {1'b0, 1'b1, 4'd0,  8'h60, 8'h42},
    {1'b1, 1'b1, 4'd0,  8'h60, 8'h42},
    {1'b0, 1'b0, 4'd15, 8'h5A, 8'h6E},
    {1'b1, 1'b1, 4'd0,  8'h5A, 8'h6E}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_page(input logic [7:0] v);
    @(negedge clk);
    bsr_we = 1'b1; bsr_wdata = v;
    @(negedge clk);
    bsr_we = 1'b0;
  endtask

  task automatic do_write(input logic bs, input logic [7:0] fa, input logic [7:0] d);
    @(negedge clk);
    bank_sel = bs; faddr = fa; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic bs, input logic [7:0] fa, output logic [7:0] d,
                         output logic v);
    @(negedge clk);
    bank_sel = bs; faddr = fa; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata; v = rvalid;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v;
    repeat (3) @(negedge clk);
    chk("R1 page reset", 32'(bsr_q), 0);
    chk("R10 rvalid reset", 32'(rvalid), 0);
    chk("R10 err reset", 32'(err), 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      set_page({4'h0, VEC[i][19:16]});
      if (VEC[i][21]) begin
        do_read(VEC[i][20], VEC[i][15:8], d, v);
        chk("R2 R3 R5 table read data", 32'(d), 32'(VEC[i][7:0]));
        chk("R5 table read valid", 32'(v), 1);
      end else begin
        do_write(VEC[i][20], VEC[i][15:8], VEC[i][7:0]);
      end
    end

    set_page(8'hF7);
    chk("R1 low bits only", 32'(bsr_q), 7);

    @(negedge clk);
    chk("R10 idle rvalid", 32'(rvalid), 0);

    // R4 window read high half, page ignored
    set_page(8'h05);
    @(negedge clk);
    bank_sel = 1'b0; faddr = 8'h80; rd_en = 1'b1;
    #1;
    chk("R4 read strobe", 32'(sfr_re), 1);
    chk("R4 port addr", 32'(sfr_addr), 32'hF80);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R6 port data returned", 32'(rdata), 32'h80 ^ 32'hC3);
    chk("R6 port rvalid", 32'(rvalid), 1);

    // R6 window write reaches port, not RAM 0x060
    @(negedge clk);
    bank_sel = 1'b0; faddr = 8'h60; wdata = 8'hE1; wr_en = 1'b1;
    #1;
    chk("R6 write strobe", 32'(sfr_we), 1);
    chk("R6 port addr", 32'(sfr_addr), 32'hF60);
    chk("R6 port wdata", 32'(sfr_wdata), 32'hE1);
    @(negedge clk);
    wr_en = 1'b0;
    set_page(8'h00);
    do_read(1'b1, 8'h60, d, v);
    chk("R6 RAM untouched", 32'(d), 32'h42);

    // R7 explicit tail of page 15
    set_page(8'h0F);
    @(negedge clk);
    bank_sel = 1'b1; faddr = 8'h5C; rd_en = 1'b1;
    #1;
    chk("R7 tail strobe", 32'(sfr_re), 1);
    chk("R7 tail addr", 32'(sfr_addr), 32'hF5C);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R7 tail data", 32'(rdata), 32'h5C ^ 32'hC3);
    @(negedge clk);
    bank_sel = 1'b0; faddr = 8'h5C; rd_en = 1'b1;
    #1;
    chk("R7 window 5C not port", 32'(sfr_re), 0);
    @(negedge clk);
    rd_en = 1'b0;

    // R8 gap accesses
    @(negedge clk);
    bank_sel = 1'b1; faddr = 8'h40; wdata = 8'hFF; wr_en = 1'b1;
    #1;
    chk("R8 gap write no strobe", 32'(sfr_we), 0);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 gap write err", 32'(err), 1);
    @(negedge clk);
    chk("R8 err one cycle", 32'(err), 0);
    do_read(1'b1, 8'h59, d, v);
    chk("R8 gap read zero", 32'(d), 0);
    chk("R8 gap read valid", 32'(v), 1);
    chk("R8 gap read err", 32'(err), 1);
    do_read(1'b1, 8'h3F, d, v);
    chk("R8 neighbour RAM kept", 32'(d), 32'h99);

    // R9 RAM survives reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 page cleared by reset", 32'(bsr_q), 0);
    rst_n = 1'b1;
    set_page(8'h03);
    do_read(1'b1, 8'h10, d, v);
    chk("R9 RAM after reset", 32'(d), 32'hA5);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule